// File: doc/BRIEF.md
# Packed 4:1:1 YUV to RGB Pixel Converter

This block sits behind a frame-capture memory reader and turns one captured scanline, delivered one byte per transfer, into a stream of 8-bit RGB pixels. The scanline is organised as 8-byte groups. Each group holds four 7-bit luma samples and a single signed chroma pair that is shared by all four pixels. The chroma pair is split into 2-bit slices spread over four bytes. The block collects a whole group, rebuilds the luma and chroma, and converts each pixel with fixed integer constants. It saturates every channel to 0..255 and emits the four pixels in order, each tagged with its index within the line.

Both sides use a valid/ready handshake. A start-of-line flag on an input byte marks that byte as offset 0 of a new line. Any data past the usable part of a line is accepted and dropped. While a group's pixels wait on the output, the input stalls.

Top module: `yuv411_rgb_conv`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1. The first byte accepted without `in_sol` counts as line offset 0.
- R2: Offsets 0, 2, 4 and 6 of a group (offset = line offset mod 8) carry the luma of pixels 0..3 in bits 7..1. The luma used is that byte with bit 0 forced to 0, and bit 0 has no effect on any output.
- R3: Offsets 1, 3, 5 and 7 carry chroma slices, most significant slice first. Bits 7..6 give U[7:6], U[5:4], U[3:2] and U[1:0]; bits 5..4 give the matching V pairs. Bits 3..0 are ignored. U and V are 8-bit two's complement and apply to all four pixels.
- R4: The scaled chroma is u = trunc(U*226/127) and v = trunc(V*179/127), with the division exact and rounded toward zero. Example: V = -128 gives v = -180.
- R5: Red = clamp(Y+v) and blue = clamp(Y+u), where clamp limits the value to 0..255.
- R6: Green = clamp(((Y*436)>>8) - ((R*130)>>8) - ((B*50)>>8)), using the clamped R and B from R5.
- R7: No pixel leaves before all 8 bytes of a group are accepted. The four pixels then leave in order 0..3, with `out_idx` = 4*(group offset/8) + pixel number.
- R8: While `out_valid` is 1, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, the pixel and its index stay unchanged in the next cycle.
- R9: A byte accepted with `in_sol` = 1 is line offset 0. Any partly collected group is abandoned, and pixel indices restart at 0.
- R10: Bytes at line offsets 1536 and above (parameter `LINE_BYTES`) are accepted but produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts the byte this cycle |
| in_data | input | 8 | Packed scanline byte |
| in_sol | input | 1 | This byte is offset 0 of a new line |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer takes the pixel this cycle |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |
| out_idx | output | IDX_W (10) | Pixel index within the line |

## Verification
Two functions overlap in time. The pixel emitter may be under backpressure, holding an output in the same cycle that the producer offers the next group's first byte. A start-of-line flag may also arrive right after a pixel handoff, or while a group is only partly collected. The bench creates these cases by randomly gapping `in_valid` and dropping `out_ready`, and it inserts start-of-line flags mid-group. It judges every handshaked pixel against a queue filled by a bench model of the byte offsets. On every stalled cycle it checks that `in_ready` is low and that the held pixel is unchanged.

// File: rtl/yuvpx_pkg.sv
package yuvpx_pkg;

    localparam int GROUP_BYTES = 8;
    localparam int PIX_PER_GRP = 4;
    localparam logic [7:0] LUMA_MASK = 8'hFE;
    localparam logic [15:0] U_GAIN = 16'sd226;
    localparam logic [15:0] V_GAIN = 16'sd179;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic signed [9:0] u;
        logic signed [9:0] v;
    } chroma_t;

    // exact signed divide by 127, truncating toward zero
    function automatic logic signed [9:0] div127_trunc(input logic signed [15:0] p);
        logic [15:0] mag;
        logic [9:0]  q;
        logic [15:0] rem;
        mag = p[15] ? 16'(-p) : 16'(p);
        q   = 10'((26'(mag) * 26'd516) >> 16);
        rem = mag - 16'(q) * 16'd127;
        if (rem >= 16'd127) q = q + 10'd1;
        return p[15] ? $signed(-q) : $signed(q);
    endfunction

    function automatic logic signed [9:0] scale_chroma(input logic [7:0] c,
                                                       input logic [15:0] gain);
        logic signed [15:0] prod;
        prod = $signed({{8{c[7]}}, c}) * $signed(gain);
        return div127_trunc(prod);
    endfunction

    function automatic logic [7:0] sat8(input logic signed [11:0] x);
        if (x < 0)           return 8'd0;
        else if (x > 12'sd255) return 8'd255;
        else                 return x[7:0];
    endfunction

endpackage

// File: rtl/yuvpx_unpack.sv
module yuvpx_unpack #(
    parameter int LINE_BYTES = 1536,
    localparam int OFF_W = $clog2(LINE_BYTES + 1),
    localparam int GRP_W = $clog2(LINE_BYTES / yuvpx_pkg::GROUP_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sol,
    output logic             in_ready,
    input  logic             grp_take,
    output logic             grp_full,
    output logic [7:0]       luma [yuvpx_pkg::PIX_PER_GRP],
    output logic [7:0]       u_raw,
    output logic [7:0]       v_raw,
    output logic [GRP_W-1:0] grp_base
);
    import yuvpx_pkg::*;

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] eff_off;
    logic [2:0]       phase;
    logic             accept;
    logic             in_line;

    assign in_ready = !grp_full;
    assign accept   = in_valid && in_ready;
    assign eff_off  = in_sol ? '0 : off_q;
    assign in_line  = eff_off < OFF_W'(LINE_BYTES);
    assign phase    = eff_off[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q    <= '0;
            grp_full <= 1'b0;
            grp_base <= '0;
            u_raw    <= '0;
            v_raw    <= '0;
        end else begin
            if (grp_take) grp_full <= 1'b0;
            if (accept) begin
                off_q <= in_line ? eff_off + OFF_W'(1) : eff_off;
                if (in_line && phase[0]) begin
                    unique case (phase[2:1])
                        2'd0: begin u_raw[7:6] <= in_data[7:6]; v_raw[7:6] <= in_data[5:4]; end
                        2'd1: begin u_raw[5:4] <= in_data[7:6]; v_raw[5:4] <= in_data[5:4]; end
                        2'd2: begin u_raw[3:2] <= in_data[7:6]; v_raw[3:2] <= in_data[5:4]; end
                        2'd3: begin u_raw[1:0] <= in_data[7:6]; v_raw[1:0] <= in_data[5:4]; end
                    endcase
                    if (phase == 3'd7) begin
                        grp_full <= 1'b1;
                        grp_base <= GRP_W'(eff_off >> 3);
                    end
                end
            end
        end
    end

    // one luma lane per pixel slot
    for (genvar k = 0; k < PIX_PER_GRP; k++) begin : g_luma
        always_ff @(posedge clk) begin
            if (rst) begin
                luma[k] <= '0;
            end else if (accept && in_line && !phase[0] && phase[2:1] == 2'(k)) begin
                luma[k] <= in_data & LUMA_MASK;
            end
        end
    end

endmodule

// File: rtl/yuvpx_chroma_scale.sv
module yuvpx_chroma_scale (
    input  logic [7:0]          u_raw,
    input  logic [7:0]          v_raw,
    output yuvpx_pkg::chroma_t  chroma
);
    import yuvpx_pkg::*;

    always_comb begin
        chroma.u = scale_chroma(u_raw, U_GAIN);
        chroma.v = scale_chroma(v_raw, V_GAIN);
    end

endmodule

// File: rtl/yuvpx_convert.sv
module yuvpx_convert (
    input  logic [7:0]         y,
    input  yuvpx_pkg::chroma_t chroma,
    output yuvpx_pkg::rgb_t    pix
);
    import yuvpx_pkg::*;

    logic signed [11:0] r_sum, b_sum, g_sum;
    logic [7:0]         r_c, b_c;
    logic [8:0]         y_term;
    logic [7:0]         r_term;
    logic [5:0]         b_term;

    always_comb begin
        r_sum  = $signed({4'b0, y}) + $signed({{2{chroma.v[9]}}, chroma.v});
        b_sum  = $signed({4'b0, y}) + $signed({{2{chroma.u[9]}}, chroma.u});
        r_c    = sat8(r_sum);
        b_c    = sat8(b_sum);
        y_term = 9'((20'(y) * 20'd436) >> 8);
        r_term = 8'((16'(r_c) * 16'd130) >> 8);
        b_term = 6'((14'(b_c) * 14'd50) >> 8);
        g_sum  = $signed({3'b0, y_term}) - $signed({4'b0, r_term}) - $signed({6'b0, b_term});
        pix.r  = r_c;
        pix.b  = b_c;
        pix.g  = sat8(g_sum);
    end

endmodule

// File: rtl/yuv411_rgb_conv.sv
module yuv411_rgb_conv #(
    parameter int LINE_BYTES = 1536,
    localparam int GRP_W = $clog2(LINE_BYTES / yuvpx_pkg::GROUP_BYTES),
    localparam int IDX_W = GRP_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_r,
    output logic [7:0]       out_g,
    output logic [7:0]       out_b,
    output logic [IDX_W-1:0] out_idx
);
    import yuvpx_pkg::*;

    logic             grp_full;
    logic             grp_take;
    logic [7:0]       luma [PIX_PER_GRP];
    logic [7:0]       u_raw, v_raw;
    logic [GRP_W-1:0] grp_base;
    logic [1:0]       sel_q;
    chroma_t          chroma;
    rgb_t             pix;

    yuvpx_unpack #(.LINE_BYTES(LINE_BYTES)) i_unpack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sol   (in_sol),
        .in_ready (in_ready),
        .grp_take (grp_take),
        .grp_full (grp_full),
        .luma     (luma),
        .u_raw    (u_raw),
        .v_raw    (v_raw),
        .grp_base (grp_base)
    );

    yuvpx_chroma_scale i_scale (
        .u_raw  (u_raw),
        .v_raw  (v_raw),
        .chroma (chroma)
    );

    yuvpx_convert i_conv (
        .y      (luma[sel_q]),
        .chroma (chroma),
        .pix    (pix)
    );

    assign out_valid = grp_full;
    assign grp_take  = out_valid && out_ready && (sel_q == 2'd3);
    assign out_r     = pix.r;
    assign out_g     = pix.g;
    assign out_b     = pix.b;
    assign out_idx   = {grp_base, sel_q};

    always_ff @(posedge clk) begin
        if (rst)                         sel_q <= '0;
        else if (out_valid && out_ready) sel_q <= sel_q + 2'd1;
    end

endmodule

// File: rtl/yuvpx_checker.sv
module yuvpx_checker #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_r,
    input logic [7:0]       out_g,
    input logic [7:0]       out_b,
    input logic [IDX_W-1:0] out_idx
);

    // R1: reset leaves the block idle and accepting
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R8: pending pixels block input
    a_r8_input_stalled: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8: a refused pixel is held unchanged
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_r, out_g, out_b, out_idx})));

    // R7: pixels of a group leave with consecutive indices
    a_r7_idx_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_idx[1:0] != 2'd3)
            |=> (out_valid && out_idx == $past(out_idx) + IDX_W'(1)));

    // R7: a fresh group starts at pixel 0
    a_r7_group_start: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_idx[1:0] == 2'd0));

endmodule

bind yuv411_rgb_conv yuvpx_checker #(.IDX_W(IDX_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .out_idx   (out_idx)
);

// File: tb/test_yuv411_rgb_conv.sv
module test_yuv411_rgb_conv;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_BYTES = 1536;
    localparam int IDX_W      = 10;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = 8'h00;
    logic             in_sol = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_r, out_g, out_b;
    logic [IDX_W-1:0] out_idx;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_out    = 0;
    int   rdy_pct  = 100;
    bit   run_mon  = 1'b0;
    exp_t exp_q[$];
    exp_t act_mem[768];
    int   m_off = 0;
    logic [7:0] m_grp[8];
    bit   held = 1'b0;
    exp_t held_val;

    yuv411_rgb_conv #(.LINE_BYTES(LINE_BYTES)) i_yuv411_rgb_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sol(in_sol), .out_valid(out_valid),
        .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_idx(out_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int clip(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    function automatic exp_t ref_pix(input int y, input int uu, input int vv, input int idx);
        exp_t e;
        int u, v, r, b, g;
        u = (uu * 226) / 127;
        v = (vv * 179) / 127;
        r = clip(y + v);
        b = clip(y + u);
        g = clip(((y * 436) >> 8) - ((r * 130) >> 8) - ((b * 50) >> 8));
        e.idx = IDX_W'(idx);
        e.r = 8'(r); e.g = 8'(g); e.b = 8'(b);
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model of line offsets and group completion
    task automatic model_byte(input logic [7:0] d, input bit sol);
        logic [7:0] uu, vv;
        if (sol) m_off = 0;
        if (m_off < LINE_BYTES) begin
            m_grp[m_off % 8] = d;
            if (m_off % 8 == 7) begin
                uu = {m_grp[1][7:6], m_grp[3][7:6], m_grp[5][7:6], m_grp[7][7:6]};
                vv = {m_grp[1][5:4], m_grp[3][5:4], m_grp[5][5:4], m_grp[7][5:4]};
                for (int k = 0; k < 4; k++)
                    exp_q.push_back(ref_pix(int'(m_grp[2*k] & 8'hFE), int'($signed(uu)),
                                            int'($signed(vv)), (m_off / 8) * 4 + k));
            end
            m_off++;
        end
    endtask

    task automatic send(input logic [7:0] d, input bit sol, input int gap);
        bit ok;
        repeat (gap) begin @(posedge clk); #1; end
        in_valid = 1'b1; in_data = d; in_sol = sol;
        forever begin
            @(negedge clk); ok = in_ready;
            @(posedge clk);
            if (ok) break;
        end
        #1;
        model_byte(d, sol);
        in_valid = 1'b0; in_sol = 1'b0; in_data = 8'($urandom);
    endtask

    task automatic send_group(input logic [7:0] y[4], input logic [7:0] u, input logic [7:0] v,
                              input bit sol, input int gap);
        for (int k = 0; k < 4; k++) begin
            send({y[k][7:1], 1'($urandom)}, sol && k == 0, gap);
            send({u[7-2*k -: 2], v[7-2*k -: 2], 4'($urandom)}, 1'b0, gap);
        end
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin @(posedge clk); t++; end
        repeat (10) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        #1;
        out_ready = ($urandom % 100) < rdy_pct;
    end

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (run_mon && !rst) begin
            exp_t a;
            a = {out_idx, out_r, out_g, out_b};
            if (held) begin
                check(out_valid && a == held_val, "R8 held pixel", 64'(a), 64'(held_val));
            end
            if (out_valid) check(!in_ready, "R8 in_ready low during output", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                n_out++;
                act_mem[out_idx] = a;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10/R7 unexpected pixel", 64'(a), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(a == e, "R2/R3/R4/R5/R6/R7/R9 pixel", 64'(a), 64'(e));
                end
            end
            held = out_valid && !out_ready;
            held_val = a;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ys[4];
        int base_out;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'd1);
        run_mon = 1'b1;
        @(posedge clk); #1;

        // directed corners: chroma extremes and clamp limits (R4/R5/R6)
        ys = '{8'd254, 8'd0, 8'd128, 8'd254};
        send_group(ys, 8'h80, 8'h80, 1'b0, 0);
        ys = '{8'd0, 8'd255, 8'd1, 8'd254};
        send_group(ys, 8'h7F, 8'h7F, 1'b0, 1);
        drain();
        check(act_mem[0] == {10'd0, 8'd74, 8'd255, 8'd27}, "R4 truncation toward zero",
              64'(act_mem[0]), 64'({10'd0, 8'd74, 8'd255, 8'd27}));
        check(act_mem[1] == {10'd1, 8'd0, 8'd0, 8'd0}, "R5 clamp low",
              64'(act_mem[1]), 64'({10'd1, 8'd0, 8'd0, 8'd0}));
        check(act_mem[4] == {10'd4, 8'd179, 8'd0, 8'd226}, "R6 green from clamped red/blue",
              64'(act_mem[4]), 64'({10'd4, 8'd179, 8'd0, 8'd226}));
        check(act_mem[5] == {10'd5, 8'd255, 8'd254, 8'd255}, "R2 bit0 ignored, R5 clamp high",
              64'(act_mem[5]), 64'({10'd5, 8'd255, 8'd254, 8'd255}));

        // R9: abandon a partial group with a new start of line
        for (int k = 0; k < 5; k++) send(8'($urandom), 1'b0, 0);
        rdy_pct = 40;
        for (int g = 0; g < 6; g++) begin
            ys = '{8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
            send_group(ys, 8'($urandom), 8'($urandom), g == 0, $urandom % 2);
        end
        drain();
        check(act_mem[0].idx == 10'd0 && n_out == 32, "R9 index restart",
              64'(n_out), 64'd32);

        // R10: full line plus bytes past the usable end
        base_out = n_out;
        rdy_pct = 70;
        for (int k = 0; k < LINE_BYTES + 24; k++) send(8'($urandom), k == 0, 0);
        drain();
        check(n_out - base_out == LINE_BYTES / 2, "R10 pixels per full line",
              64'(n_out - base_out), 64'(LINE_BYTES / 2));
        check(act_mem[767].idx == 10'd767, "R7 last index of line",
              64'(act_mem[767].idx), 64'd767);

        // random lines with mid-group restarts and heavy backpressure
        for (int l = 0; l < 6; l++) begin
            int len = 8 + ($urandom % 120);
            rdy_pct = 20 + 15 * l;
            for (int k = 0; k < len; k++) send(8'($urandom), k == 0, $urandom % 3);
        end
        drain();
        check(exp_q.size() == 0, "R7 all expected pixels delivered", 64'(exp_q.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule